// File: doc/BRIEF.md
# Program and Data Memory Banking Unit

This block sits between an 8-bit core and its memories and turns core addresses into physical program-memory addresses and data-bank chip selects. The 12-bit program counter reaches a 13-bit program ROM. When the counter's top bit is set, it addresses a fixed shared page. When that bit is clear, it addresses a switchable page that software picks. A 64-byte slice of the data space is a read-only view into program memory. The core positions this view in 64-byte steps. The lowest 64 bytes of data space are served by one of several RAM or EEPROM banks, chosen by a code that software writes.

Software sets up the three selections by writing to three data-space addresses. These registers cannot be read back. They have no defined value after reset. Interrupts and calls leave them unchanged, because they change only on a write to their own address. The block tracks which registers have been written since reset. It flags any fetch or data access that depends on a register not yet written. It also flags bank codes that would enable more than one bank. Reads from the window and banked regions go through a registered multiplexer and return one cycle after the address.

Top module: `mem_bank_map`

## Requirements
- R1: With pc[11] = 0, fetch_addr = {page register, pc[10:0]}, where the page register is the low 2 bits last written to data address CAh.
- R2: With pc[11] = 1, fetch_addr = {2'b01, pc[10:0]} whatever the page register holds, and fetch_unset stays low.
- R3: A read (d_re = 1, d_we = 0) of data address 40h–7Fh with the window register written raises rom_dre and drives rom_daddr = {window register, d_addr[5:0]}, where the window register is the low 6 bits last written to C9h (window 28h, address 59h gives A19h).
- R4: A write to C9h, CAh or CBh updates only that register, and the new value is used from the next cycle. Writes to any other address leave all three unchanged.
- R5: The bank code is the full byte last written to CBh. During a read or write of 00h–3Fh, code 01h raises bank_cs[0], 02h raises bank_cs[1], 08h raises bank_cs[2] and 10h raises bank_cs[3]. Code 00h raises none. bank_cs is all zero outside such an access.
- R6: Any written bank code other than 00h, 01h, 02h, 08h or 10h raises bank_err and enables no bank.
- R7: Reset clears the written-since-reset state but not the register values. fetch_unset is high while pc[11] = 0 and the page register is unwritten. acc_fault is high for any access to 40h–7Fh while the window register is unwritten, and for any access to 00h–3Fh unless the bank register holds a legal nonzero code.
- R8: A read of 00h–7Fh gives, one cycle later, either rd_vld = 1 with rd_data taken from prog_rdata (window) or from the selected bank_rdata byte (bank i on bits 8i+7:8i), or rd_bad = 1 with rd_data = 0 when that read faulted. Otherwise both flags are low.
- R9: A write to 40h–7Fh is rejected: it raises acc_fault and does not raise rom_dre.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| d_addr | input | 8 | Data-space address |
| d_we | input | 1 | Data-space write strobe |
| d_re | input | 1 | Data-space read strobe |
| d_wdata | input | 8 | Data-space write data |
| pc | input | 12 | Core program counter |
| fetch_addr | output | 13 | Physical program ROM fetch address |
| fetch_unset | output | 1 | Fetch depends on an unwritten page register |
| rom_daddr | output | 12 | Program memory address for window reads |
| rom_dre | output | 1 | Window read strobe to program memory |
| prog_rdata | input | 8 | Byte returned by program memory for rom_daddr |
| bank_rdata | input | 32 | Read bytes of the four banks, bank i in bits 8i+7:8i |
| bank_cs | output | 4 | One-hot bank chip selects: EEPROM 0, EEPROM 1, RAM 1, RAM 2 |
| bank_err | output | 1 | Bank register holds an illegal code |
| acc_fault | output | 1 | Current data access is invalid |
| rd_data | output | 8 | Registered read data |
| rd_vld | output | 1 | rd_data holds a valid window or bank read |
| rd_bad | output | 1 | The read of the previous cycle faulted |

## Verification
Random program counters cover both halves of the fetch range, and every page value is written. This shows the static alias apart from the switched path. The window is exercised with random positions and offsets, including the A19h case. Because the modelled program memory returns a hash of its address, a wrong concatenation shows up in rd_data as well as on rom_daddr. Bank codes are drawn from the legal set and from random bytes, so single legal selects are told apart from code 00h, multi-bit codes and stray upper bits. Accesses made right after reset, and again after a reset in mid-run, separate the never-written state from a written one. Writes to addresses next to the registers confirm that the decode is exact.

// File: rtl/mbm_pkg.sv
package mbm_pkg;

    localparam int DADDR_W   = 8;
    localparam int NUM_BANKS = 4;

    // Bit position in the bank code that selects each bank output
    // (index 0: EEPROM 0, 1: EEPROM 1, 2: RAM 1, 3: RAM 2).
    localparam int BANK_BIT [NUM_BANKS] = '{0, 1, 3, 4};

    typedef enum logic [1:0] {
        RGN_BANKED = 2'd0,
        RGN_WINDOW = 2'd1,
        RGN_PLAIN  = 2'd2
    } region_e;

    function automatic region_e region_of(input logic [DADDR_W-1:0] a);
        case (a[DADDR_W-1 -: 2])
            2'b00:   return RGN_BANKED;
            2'b01:   return RGN_WINDOW;
            default: return RGN_PLAIN;
        endcase
    endfunction

endpackage

// File: rtl/mbm_cfg_regs.sv
module mbm_cfg_regs #(
    parameter int              PAGE_W    = 2,
    parameter int              WIN_W     = 6,
    parameter int              BANK_W    = 8,
    parameter int              DATA_W    = 8,
    parameter int              A_W       = 8,
    parameter logic [A_W-1:0]  ADDR_WIN  = 8'hC9,
    parameter logic [A_W-1:0]  ADDR_PAGE = 8'hCA,
    parameter logic [A_W-1:0]  ADDR_BANK = 8'hCB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [A_W-1:0]    addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [PAGE_W-1:0] page_q,
    output logic [WIN_W-1:0]  win_q,
    output logic [BANK_W-1:0] bank_q,
    output logic              page_ok,
    output logic              win_ok,
    output logic              bank_ok
);

    typedef struct packed {
        logic [PAGE_W-1:0] page;
        logic [WIN_W-1:0]  win;
        logic [BANK_W-1:0] bank;
    } cfg_t;

    typedef struct packed {
        logic page;
        logic win;
        logic bank;
    } seen_t;

    cfg_t  cfg_d,  cfg_q;
    seen_t seen_d, seen_q;

    always_comb begin
        cfg_d  = cfg_q;
        seen_d = seen_q;
        if (we) begin
            if (addr == ADDR_PAGE) begin
                cfg_d.page  = wdata[PAGE_W-1:0];
                seen_d.page = 1'b1;
            end
            if (addr == ADDR_WIN) begin
                cfg_d.win  = wdata[WIN_W-1:0];
                seen_d.win = 1'b1;
            end
            if (addr == ADDR_BANK) begin
                cfg_d.bank  = wdata[BANK_W-1:0];
                seen_d.bank = 1'b1;
            end
        end
    end

    // The register values themselves are deliberately left without reset.
    always_ff @(posedge clk) begin
        cfg_q <= cfg_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= '0;
        end else begin
            seen_q <= seen_d;
        end
    end

    assign page_q  = cfg_q.page;
    assign win_q   = cfg_q.win;
    assign bank_q  = cfg_q.bank;
    assign page_ok = seen_q.page;
    assign win_ok  = seen_q.win;
    assign bank_ok = seen_q.bank;

    AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (page_ok && !(we && addr == ADDR_PAGE)) |=> $stable(page_q)); // R4
    AST_WIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (win_ok && !(we && addr == ADDR_WIN)) |=> $stable(win_q)); // R4
    AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_ok && !(we && addr == ADDR_BANK)) |=> $stable(bank_q)); // R4
    AST_SEEN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        page_ok |=> page_ok); // R7

endmodule

// File: rtl/mbm_addr_map.sv
module mbm_addr_map #(
    parameter int PC_W        = 12,
    parameter int PAGE_W      = 2,
    parameter int STATIC_PAGE = 1,
    parameter int WIN_W       = 6,
    parameter int WOFS_W      = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [PC_W-1:0]          pc,
    input  logic [PAGE_W-1:0]        page_q,
    input  logic                     page_ok,
    input  logic [WIN_W-1:0]         win_q,
    input  logic [WOFS_W-1:0]        win_ofs,
    output logic [PC_W+PAGE_W-2:0]   fetch_addr,
    output logic                     fetch_unset,
    output logic [WIN_W+WOFS_W-1:0]  rom_daddr
);

    localparam int OFS_W  = PC_W - 1;
    localparam int ROM_AW = OFS_W + PAGE_W;
    localparam logic [PAGE_W-1:0] STATIC_SEL = PAGE_W'(STATIC_PAGE);

    logic              use_static;
    logic [PAGE_W-1:0] page_sel;

    always_comb begin
        use_static  = pc[PC_W-1];
        page_sel    = use_static ? STATIC_SEL : page_q;
        fetch_addr  = {page_sel, pc[OFS_W-1:0]};
        fetch_unset = !use_static && !page_ok;
        rom_daddr   = {win_q, win_ofs};
    end

    AST_STATIC_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
        pc[PC_W-1] |-> (fetch_addr[ROM_AW-1:OFS_W] == STATIC_SEL && !fetch_unset)); // R2
    AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_addr[OFS_W-1:0] == pc[OFS_W-1:0]); // R1

endmodule

// File: rtl/mbm_bank_dec.sv
module mbm_bank_dec #(
    parameter int BANK_W = 8,
    parameter int NB     = mbm_pkg::NUM_BANKS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BANK_W-1:0] bank_q,
    input  logic              bank_ok,
    input  logic              access,
    output logic [NB-1:0]     cs,
    output logic              err,
    output logic              sel_ok
);

    logic [NB-1:0] hit;
    logic          code_zero;
    logic          code_legal;

    for (genvar g = 0; g < NB; g++) begin : g_code
        localparam logic [BANK_W-1:0] CODE = BANK_W'(1) << mbm_pkg::BANK_BIT[g];
        assign hit[g] = (bank_q == CODE);
    end

    always_comb begin
        code_zero  = (bank_q == '0);
        code_legal = code_zero || (|hit);
        sel_ok     = bank_ok && (|hit);
        err        = bank_ok && !code_legal;
        cs         = (access && bank_ok) ? hit : '0;
    end

    AST_BANK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cs)); // R5
    AST_ERR_NO_CS: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (cs == '0)); // R6
    AST_CS_NEEDS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        !access |-> (cs == '0)); // R5

endmodule

// File: rtl/mbm_rd_mux.sv
module mbm_rd_mux #(
    parameter int DATA_W = 8,
    parameter int NB     = mbm_pkg::NUM_BANKS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rd_win,
    input  logic                 rd_bank,
    input  logic                 fault,
    input  logic [DATA_W-1:0]    prog_rdata,
    input  logic [NB*DATA_W-1:0] bank_rdata,
    input  logic [NB-1:0]        cs,
    output logic [DATA_W-1:0]    rd_data,
    output logic                 rd_vld,
    output logic                 rd_bad
);

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              vld;
        logic              bad;
    } rd_t;

    rd_t               rd_d, rd_q;
    logic [DATA_W-1:0] bank_sel;
    logic              hit_any;

    always_comb begin
        bank_sel = '0;
        for (int i = 0; i < NB; i++) begin
            if (cs[i]) begin
                bank_sel = bank_sel | bank_rdata[i*DATA_W +: DATA_W];
            end
        end
        hit_any  = rd_win || rd_bank;
        rd_d.vld = hit_any && !fault;
        rd_d.bad = hit_any && fault;
        if (!rd_d.vld) begin
            rd_d.data = '0;
        end else if (rd_win) begin
            rd_d.data = prog_rdata;
        end else begin
            rd_d.data = bank_sel;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rd_data = rd_q.data;
    assign rd_vld  = rd_q.vld;
    assign rd_bad  = rd_q.bad;

    AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_win || rd_bank) |=> (rd_vld != rd_bad)); // R8
    AST_BAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_bad |-> (rd_data == '0)); // R8
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_win || rd_bank) |=> !(rd_vld || rd_bad)); // R8

endmodule

// File: rtl/mem_bank_map.sv
module mem_bank_map #(
    parameter int              PC_W        = 12,
    parameter int              PAGE_W      = 2,
    parameter int              STATIC_PAGE = 1,
    parameter int              WIN_W       = 6,
    parameter int              BANK_W      = 8,
    parameter int              DATA_W      = 8,
    parameter logic [7:0]      ADDR_WIN    = 8'hC9,
    parameter logic [7:0]      ADDR_PAGE   = 8'hCA,
    parameter logic [7:0]      ADDR_BANK   = 8'hCB
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic [mbm_pkg::DADDR_W-1:0]            d_addr,
    input  logic                                   d_we,
    input  logic                                   d_re,
    input  logic [DATA_W-1:0]                      d_wdata,
    input  logic [PC_W-1:0]                        pc,
    output logic [PC_W+PAGE_W-2:0]                 fetch_addr,
    output logic                                   fetch_unset,
    output logic [WIN_W+mbm_pkg::DADDR_W-3:0]      rom_daddr,
    output logic                                   rom_dre,
    input  logic [DATA_W-1:0]                      prog_rdata,
    input  logic [mbm_pkg::NUM_BANKS*DATA_W-1:0]   bank_rdata,
    output logic [mbm_pkg::NUM_BANKS-1:0]          bank_cs,
    output logic                                   bank_err,
    output logic                                   acc_fault,
    output logic [DATA_W-1:0]                      rd_data,
    output logic                                   rd_vld,
    output logic                                   rd_bad
);

    import mbm_pkg::*;

    localparam int WOFS_W = DADDR_W - 2;
    localparam int NB     = NUM_BANKS;

    logic [PAGE_W-1:0] page_q;
    logic [WIN_W-1:0]  win_q;
    logic [BANK_W-1:0] bank_q;
    logic              page_ok, win_ok, bank_ok;
    logic              sel_ok;
    region_e           rgn;
    logic              is_win, is_bank, touch;
    logic              fault_win, fault_bank;

    always_comb begin
        rgn        = region_of(d_addr);
        is_win     = (rgn == RGN_WINDOW);
        is_bank    = (rgn == RGN_BANKED);
        touch      = d_re || d_we;
        fault_win  = is_win && touch && (d_we || !win_ok);
        fault_bank = is_bank && touch && !sel_ok;
        acc_fault  = fault_win || fault_bank;
        rom_dre    = is_win && d_re && !d_we && win_ok;
    end

    mbm_cfg_regs #(
        .PAGE_W(PAGE_W), .WIN_W(WIN_W), .BANK_W(BANK_W), .DATA_W(DATA_W),
        .A_W(DADDR_W), .ADDR_WIN(ADDR_WIN), .ADDR_PAGE(ADDR_PAGE), .ADDR_BANK(ADDR_BANK)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(d_we), .addr(d_addr), .wdata(d_wdata),
        .page_q(page_q), .win_q(win_q), .bank_q(bank_q),
        .page_ok(page_ok), .win_ok(win_ok), .bank_ok(bank_ok)
    );

    mbm_addr_map #(
        .PC_W(PC_W), .PAGE_W(PAGE_W), .STATIC_PAGE(STATIC_PAGE),
        .WIN_W(WIN_W), .WOFS_W(WOFS_W)
    ) u_map (
        .clk(clk), .rst_n(rst_n), .pc(pc), .page_q(page_q), .page_ok(page_ok),
        .win_q(win_q), .win_ofs(d_addr[WOFS_W-1:0]),
        .fetch_addr(fetch_addr), .fetch_unset(fetch_unset), .rom_daddr(rom_daddr)
    );

    mbm_bank_dec #(.BANK_W(BANK_W), .NB(NB)) u_bank (
        .clk(clk), .rst_n(rst_n), .bank_q(bank_q), .bank_ok(bank_ok),
        .access(is_bank && touch), .cs(bank_cs), .err(bank_err), .sel_ok(sel_ok)
    );

    mbm_rd_mux #(.DATA_W(DATA_W), .NB(NB)) u_rd (
        .clk(clk), .rst_n(rst_n),
        .rd_win(is_win && d_re), .rd_bank(is_bank && d_re), .fault(acc_fault),
        .prog_rdata(prog_rdata), .bank_rdata(bank_rdata), .cs(bank_cs),
        .rd_data(rd_data), .rd_vld(rd_vld), .rd_bad(rd_bad)
    );

    AST_FAULT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        acc_fault |-> (bank_cs == '0 && !rom_dre)); // R7
    AST_WIN_WRITE_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (d_we && is_win) |-> (acc_fault && !rom_dre)); // R9

endmodule

// File: tb/mem_bank_map_tb.sv
module mem_bank_map_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  d_addr = '0;
    logic        d_we = 1'b0;
    logic        d_re = 1'b0;
    logic [7:0]  d_wdata = '0;
    logic [11:0] pc = '0;
    logic [12:0] fetch_addr;
    logic        fetch_unset;
    logic [11:0] rom_daddr;
    logic        rom_dre;
    logic [7:0]  prog_rdata;
    logic [31:0] bank_rdata;
    logic [3:0]  bank_cs;
    logic        bank_err, acc_fault;
    logic [7:0]  rd_data;
    logic        rd_vld, rd_bad;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    mem_bank_map u_dut (
        .clk(clk), .rst_n(rst_n), .d_addr(d_addr), .d_we(d_we), .d_re(d_re),
        .d_wdata(d_wdata), .pc(pc), .fetch_addr(fetch_addr), .fetch_unset(fetch_unset),
        .rom_daddr(rom_daddr), .rom_dre(rom_dre), .prog_rdata(prog_rdata),
        .bank_rdata(bank_rdata), .bank_cs(bank_cs), .bank_err(bank_err),
        .acc_fault(acc_fault), .rd_data(rd_data), .rd_vld(rd_vld), .rd_bad(rd_bad)
    );

    // Memory models seen by the block
    function automatic logic [7:0] hsh(input logic [11:0] a);
        return a[7:0] ^ {a[11:8], a[11:8]} ^ 8'hA5;
    endfunction

    function automatic logic [7:0] bank_word(input int i, input logic [7:0] a);
        return (8'h11 * 8'(i + 1)) ^ {2'b00, a[5:0]};
    endfunction

    always_comb begin
        prog_rdata = hsh(rom_daddr);
        for (int i = 0; i < 4; i++) bank_rdata[i*8 +: 8] = bank_word(i, d_addr);
    end

    // Reference model: register values start unknown
    logic [1:0] m_page = 'x;
    logic [5:0] m_win  = 'x;
    logic [7:0] m_bank = 'x;
    bit m_page_ok = 0, m_win_ok = 0, m_bank_ok = 0;
    bit p_pend = 0, p_vld = 0, p_bad = 0;
    logic [7:0] p_data = '0;

    function automatic int bank_idx(input logic [7:0] code);
        case (code)
            8'h01: return 0;
            8'h02: return 1;
            8'h08: return 2;
            8'h10: return 3;
            default: return -1;
        endcase
    endfunction

    task automatic ck(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_reg();
        if (p_pend) begin
            ck(rd_vld == p_vld, "R8 rd_vld", rd_vld, p_vld);
            ck(rd_bad == p_bad, "R8 rd_bad", rd_bad, p_bad);
            ck(rd_data == p_data, "R8 rd_data", rd_data, p_data);
        end
    endtask

    task automatic step(input bit we, input bit re, input logic [7:0] a,
                        input logic [7:0] wd, input logic [11:0] p);
        bit is_win, is_bank, touch, e_fault, e_dre, e_err;
        int idx;
        logic [3:0] e_cs;
        logic [12:0] e_fetch;
        @(negedge clk);
        check_reg();
        d_we = we; d_re = re; d_addr = a; d_wdata = wd; pc = p;
        #1;
        // Fetch path
        if (p[11]) begin
            e_fetch = {2'b01, p[10:0]};
            ck(fetch_addr == e_fetch, "R2 static fetch", fetch_addr, e_fetch);
        end else if (m_page_ok) begin
            e_fetch = {m_page, p[10:0]};
            ck(fetch_addr == e_fetch, "R1 paged fetch", fetch_addr, e_fetch);
        end
        ck(fetch_unset == (!p[11] && !m_page_ok), "R7 fetch_unset", fetch_unset,
           int'(!p[11] && !m_page_ok));
        // Data side
        is_win  = (a[7:6] == 2'b01);
        is_bank = (a[7:6] == 2'b00);
        touch   = we || re;
        idx     = m_bank_ok ? bank_idx(m_bank) : -1;
        e_err   = m_bank_ok && (m_bank != 8'h00) && (idx < 0);
        e_fault = (is_win && touch && (we || !m_win_ok)) ||
                  (is_bank && touch && (idx < 0));
        e_dre   = is_win && re && !we && m_win_ok;
        e_cs    = (is_bank && touch && idx >= 0) ? 4'(1 << idx) : 4'h0;
        ck(bank_err == e_err, "R6 bank_err", bank_err, e_err);
        ck(bank_cs == e_cs, "R5 bank_cs", bank_cs, e_cs);
        if (is_win && we) ck(acc_fault == e_fault, "R9 window write", acc_fault, e_fault);
        else ck(acc_fault == e_fault, "R7 acc_fault", acc_fault, e_fault);
        ck(rom_dre == e_dre, "R3 rom_dre", rom_dre, e_dre);
        if (e_dre) ck(rom_daddr == {m_win, a[5:0]}, "R3 rom_daddr", rom_daddr, {m_win, a[5:0]});
        // Registered read result expected after the next edge
        p_pend = 1;
        p_vld  = re && (is_win || is_bank) && !e_fault;
        p_bad  = re && (is_win || is_bank) && e_fault;
        p_data = !p_vld ? 8'h00 : is_win ? hsh({m_win, a[5:0]}) : bank_word(idx, a);
        // Model update at the coming edge (R4)
        if (we) begin
            if (a == 8'hC9) begin m_win  = wd[5:0]; m_win_ok  = 1; end
            if (a == 8'hCA) begin m_page = wd[1:0]; m_page_ok = 1; end
            if (a == 8'hCB) begin m_bank = wd;      m_bank_ok = 1; end
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        d_we = 0; d_re = 0;
        rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        m_page = 'x; m_win = 'x; m_bank = 'x;
        m_page_ok = 0; m_win_ok = 0; m_bank_ok = 0;
        p_pend = 0;
        ck(!rd_vld && !rd_bad && rd_data == 0, "R7 reset state", {rd_vld, rd_bad}, 0);
    endtask

    initial begin
        logic [7:0] codes [6] = '{8'h00, 8'h01, 8'h02, 8'h08, 8'h10, 8'h03};
        void'($urandom(32'h5EED_0042));
        do_reset();
        // Accesses before any write (R7)
        step(0, 0, 8'h90, 8'h00, 12'h123);
        step(0, 1, 8'h45, 8'h00, 12'h8AB);   // R2 with page unwritten
        step(0, 1, 8'h12, 8'h00, 12'h000);
        step(1, 0, 8'h20, 8'h5C, 12'h000);
        // Window example: 28h and 59h give A19h (R3)
        step(1, 0, 8'hC9, 8'h28, 12'h000);
        step(0, 1, 8'h59, 8'h00, 12'h000);
        step(1, 0, 8'h59, 8'h33, 12'h000);   // R9
        // Page register and static alias (R1, R2)
        step(1, 0, 8'hCA, 8'h03, 12'h000);
        step(0, 0, 8'h90, 8'h00, 12'h7FF);
        step(0, 0, 8'h90, 8'h00, 12'hFFF);
        // Neighbour writes change nothing (R4)
        step(1, 0, 8'hC8, 8'h00, 12'h100);
        step(1, 0, 8'hCC, 8'h00, 12'h100);
        step(0, 0, 8'h90, 8'h00, 12'h100);
        // Every bank code, legal and illegal (R5, R6)
        foreach (codes[k]) begin
            step(1, 0, 8'hCB, codes[k], 12'h000);
            step(0, 1, 8'h3F, 8'h00, 12'h000);
            step(1, 0, 8'h05, 8'hEE, 12'h000);
        end
        step(1, 0, 8'hCB, 8'h20, 12'h000);
        step(0, 1, 8'h00, 8'h00, 12'h000);
        // Random traffic
        for (int n = 0; n < 3000; n++) begin
            int r;
            logic [7:0] a, wd;
            bit we, re;
            r = int'($urandom % 10);
            wd = 8'($urandom);
            we = 0; re = 0;
            case (r)
                0: begin
                    we = 1;
                    a = 8'hC9 + 8'($urandom % 3);
                    if (a == 8'hCB && ($urandom % 4) != 0) wd = codes[$urandom % 5];
                end
                1: begin we = 1; a = (($urandom % 2) != 0) ? 8'hC8 : 8'hCC; end
                2, 3, 4: begin re = 1; a = 8'h40 | 8'($urandom % 64); end
                5, 6: begin re = 1; a = 8'($urandom % 64); end
                7: begin we = 1; a = 8'($urandom % 64); end
                8: begin we = 1; a = 8'h40 | 8'($urandom % 64); end
                default: begin re = 1; a = 8'h80 | 8'($urandom % 128); end
            endcase
            step(we, re, a, wd, 12'($urandom));
            if (n == 1500) do_reset();
        end
        step(0, 0, 8'h90, 8'h00, 12'h000);
        @(negedge clk);
        check_reg();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule